// File: doc/BRIEF.md
# Scatter-Gather Descriptor Walker

This block runs a chain of memory transfers that lie in memory as a linked list, with no processor work between transfers. Software places the address of the first descriptor in a small register slave and sets a start bit. The walker then fetches each descriptor over a memory-mapped read master. For every descriptor marked as owned by hardware it builds two commands: one for a read engine (source address, length, address-increment flag) and one for a write engine (destination address, length, address-increment flag, packet-marker flag). It queues them in two internal command FIFOs and follows the next pointer to the following descriptor.

The write engine returns one status token per command, giving the number of bytes it actually wrote. The walker stores that count into the descriptor's status word through a memory-mapped write master. It then rewrites the descriptor's control word with the ownership bit cleared, so software can see that the descriptor has been handed back. At most `MAX_OUT` descriptors (two by default) are in flight between issue and write-back. The walk ends at the first descriptor whose ownership bit is clear. Once every outstanding descriptor has been written back, the busy flag falls and the interrupt output rises.

A descriptor is five 32-bit words at byte offsets 0 (source), 4 (destination), 8 (next-descriptor pointer), 12 (control) and 16 (status). The control word holds the length in bits 15:0, the read-increment flag in bit 16, the write-increment flag in bit 17, the packet-marker flag in bit 18 and the hardware-ownership flag in bit 31. Bits 30:19 are free for software.

Top module: `sgd_walker`

## Requirements
- R1: After reset, irq, rd_req, wr_req, rcmd_valid, wcmd_valid and sts_ready are all 0, and both register words read 0.
- R2: A write to register address 0 sets the list head pointer, which reads back at address 0. Writing 1 to bit 0 of address 1 while idle starts a walk at the current head pointer. A later change to the head register does not affect a walk that has already started.
- R3: For each descriptor the control word (offset 12) is read first. If bit 31 of that word is set, the words at offsets 0, 4 and 8 are then read in that order. The read address stays stable until rd_valid answers the request.
- R4: Each owned descriptor yields one read command {source, control[15:0], control[16]} and one write command {destination, control[15:0], control[17], control[18]}. Commands appear in list order, and the walk follows the pointer at offset 8.
- R5: A descriptor whose control bit 31 is clear ends the walk. No command is issued for it, its other words are not read and it is never written.
- R6: No more than MAX_OUT descriptors are outstanding at any time (control word fetched and owned, write-back not finished), and no fetch starts while MAX_OUT are outstanding.
- R7: Each status token's byte count is written to offset 16 of the oldest outstanding descriptor. The descriptor's control word is then written back with bit 31 cleared and every other bit unchanged. Descriptors are written back in issue order.
- R8: Once the walk has stopped and every write-back is done, busy falls and irq rises in the same cycle. Register address 1 reads {done in bit 1, busy in bit 0}. irq stays high until 1 is written to bit 1 of address 1 or a new walk starts.
- R9: A start write made while a walk is busy is ignored.
- R10: sts_ready is high only while a descriptor is outstanding and no write-back is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Register write strobe |
| csr_addr | input | 2 | Register address (0 head pointer, 1 control/status) |
| csr_wdata | input | 32 | Register write data |
| csr_rdata | output | 32 | Registered read data for csr_addr |
| irq | output | 1 | Walk-complete interrupt (done flag) |
| rd_req | output | 1 | Read master request, held until rd_valid |
| rd_addr | output | 32 | Read master byte address |
| rd_valid | input | 1 | Read data valid, answers rd_req |
| rd_data | input | 32 | Read data |
| wr_req | output | 1 | Write master request, held until wr_ack |
| wr_addr | output | 32 | Write master byte address |
| wr_data | output | 32 | Write master data |
| wr_ack | input | 1 | Write accepted |
| rcmd_valid | output | 1 | Read-engine command available |
| rcmd_ready | input | 1 | Read engine takes the command |
| rcmd_src | output | 32 | Read command source address |
| rcmd_len | output | 16 | Read command byte count |
| rcmd_incr | output | 1 | Read command address-increment flag |
| wcmd_valid | output | 1 | Write-engine command available |
| wcmd_ready | input | 1 | Write engine takes the command |
| wcmd_dst | output | 32 | Write command destination address |
| wcmd_len | output | 16 | Write command byte count |
| wcmd_incr | output | 1 | Write command address-increment flag |
| wcmd_pkt | output | 1 | Write command start/end-of-packet marker flag |
| sts_valid | input | 1 | Status token available |
| sts_ready | output | 1 | Walker accepts the status token |
| sts_bytes | input | 32 | Bytes actually written for the oldest command |

## Verification
The case that matters most is a descriptor being issued (pushed into the tracker) on the same clock edge that an older descriptor retires (popped after its control word is written back). A second case is a status token being accepted while the read master is still partway through a descriptor fetch. The bench provokes both by sweeping chain lengths from zero to four against three engine behaviours: engines that are always ready and return tokens at once, engines that accept a command only every other cycle and return tokens after a short delay, and engines that hold each token for twenty cycles. The results are judged at the ports. A bench monitor counts fetched-but-unretired descriptors and must never exceed two, and must reach two under the slow-token behaviour. The read-address log, both command streams and every written-back status and control word are compared against values computed arithmetically from the chain layout.

// File: rtl/sgd_pkg.sv
package sgd_pkg;
  localparam int WORD_W   = 32;
  localparam int LEN_W    = 16;
  localparam int OWN_BIT  = 31;
  localparam int RINC_BIT = 16;
  localparam int WINC_BIT = 17;
  localparam int PKT_BIT  = 18;

  // byte offsets of the words inside one descriptor
  localparam logic [4:0] OFF_SRC = 5'd0;
  localparam logic [4:0] OFF_DST = 5'd4;
  localparam logic [4:0] OFF_NXT = 5'd8;
  localparam logic [4:0] OFF_CTL = 5'd12;
  localparam logic [4:0] OFF_STS = 5'd16;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              incr;
  } rd_cmd_t;

  typedef struct packed {
    logic [WORD_W-1:0] addr;
    logic [LEN_W-1:0]  len;
    logic              incr;
    logic              pkt;
  } wr_cmd_t;

  typedef struct packed {
    logic [WORD_W-1:0] ptr;
    logic [WORD_W-1:0] ctl;
  } trk_t;

  typedef enum logic [2:0] {F_IDLE, F_READ, F_ISSUE, F_HOLD, F_DRAIN} fetch_st_t;
  typedef enum logic [1:0] {W_IDLE, W_SIZE, W_CTL} wb_st_t;
endpackage

// File: rtl/sgd_fifo.sv
module sgd_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic          full,
  output logic          empty,
  output logic [CW-1:0] count
);
  logic [W-1:0]  store [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [CW-1:0] cnt;

  function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (push) wp <= bump(wp);
      if (pop)  rp <= bump(rp);
      cnt <= cnt + CW'(push) - CW'(pop);
    end
  end

  assign dout  = store[rp];
  assign count = cnt;
  assign full  = (cnt == CW'(DEPTH));
  assign empty = (cnt == '0);

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    push |-> (!full || pop));
  assert_no_underflow_R7: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/sgd_fetch.sv
module sgd_fetch import sgd_pkg::*; #(
  parameter int MAX_OUT = 2,
  localparam int CW     = $clog2(MAX_OUT + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [WORD_W-1:0] head,
  input  logic [CW-1:0]     trk_count,
  input  logic              trk_empty,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              issue,
  output rd_cmd_t           rcmd,
  output wr_cmd_t           wcmd,
  output trk_t              trk_ent,
  output logic              finish
);
  fetch_st_t         st;
  logic [1:0]        widx;
  logic [WORD_W-1:0] cur, src_q, dst_q, nxt_q, ctl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= F_IDLE;
      rd_req  <= 1'b0;
      rd_addr <= '0;
      widx    <= '0;
      cur     <= '0;
      src_q   <= '0;
      dst_q   <= '0;
      nxt_q   <= '0;
      ctl_q   <= '0;
    end else begin
      case (st)
        F_IDLE: if (start) begin
          cur     <= head;
          rd_req  <= 1'b1;
          rd_addr <= head + WORD_W'(OFF_CTL);
          widx    <= 2'd0;
          st      <= F_READ;
        end
        F_READ: if (rd_valid) begin
          case (widx)
            2'd0: begin
              ctl_q <= rd_data;
              if (!rd_data[OWN_BIT]) begin
                rd_req <= 1'b0;
                st     <= F_DRAIN;
              end else begin
                rd_addr <= cur + WORD_W'(OFF_SRC);
                widx    <= 2'd1;
              end
            end
            2'd1: begin
              src_q   <= rd_data;
              rd_addr <= cur + WORD_W'(OFF_DST);
              widx    <= 2'd2;
            end
            2'd2: begin
              dst_q   <= rd_data;
              rd_addr <= cur + WORD_W'(OFF_NXT);
              widx    <= 2'd3;
            end
            default: begin
              nxt_q  <= rd_data;
              rd_req <= 1'b0;
              st     <= F_ISSUE;
            end
          endcase
        end
        F_ISSUE: begin
          cur <= nxt_q;
          st  <= F_HOLD;
        end
        F_HOLD: if (trk_count < CW'(MAX_OUT)) begin
          rd_req  <= 1'b1;
          rd_addr <= cur + WORD_W'(OFF_CTL);
          widx    <= 2'd0;
          st      <= F_READ;
        end
        F_DRAIN: if (trk_empty) st <= F_IDLE;
        default: st <= F_IDLE;
      endcase
    end
  end

  assign issue   = (st == F_ISSUE);
  assign finish  = (st == F_DRAIN) && trk_empty;
  assign rcmd    = '{addr: src_q, len: ctl_q[LEN_W-1:0], incr: ctl_q[RINC_BIT]};
  assign wcmd    = '{addr: dst_q, len: ctl_q[LEN_W-1:0], incr: ctl_q[WINC_BIT],
                     pkt: ctl_q[PKT_BIT]};
  assign trk_ent = '{ptr: cur, ctl: ctl_q};

  assert_fetch_window_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (trk_count < CW'(MAX_OUT)));
  assert_read_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !rd_valid) |=> (rd_req && $stable(rd_addr)));
  assert_issue_owned_R5: assert property (@(posedge clk) disable iff (rst)
    issue |-> ctl_q[OWN_BIT]);
endmodule

// File: rtl/sgd_writeback.sv
module sgd_writeback import sgd_pkg::*; (
  input  logic              clk,
  input  logic              rst,
  input  logic              trk_empty,
  input  trk_t              trk_head,
  output logic              trk_pop,
  input  logic              sts_valid,
  output logic              sts_ready,
  input  logic [WORD_W-1:0] sts_bytes,
  output logic              wr_req,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_ack
);
  wb_st_t            st;
  logic [WORD_W-1:0] ctl_ret;

  always_comb begin
    ctl_ret          = trk_head.ctl;
    ctl_ret[OWN_BIT] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= W_IDLE;
      wr_req  <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      case (st)
        W_IDLE: if (sts_valid && sts_ready) begin
          wr_req  <= 1'b1;
          wr_addr <= trk_head.ptr + WORD_W'(OFF_STS);
          wr_data <= sts_bytes;
          st      <= W_SIZE;
        end
        W_SIZE: if (wr_ack) begin
          wr_addr <= trk_head.ptr + WORD_W'(OFF_CTL);
          wr_data <= ctl_ret;
          st      <= W_CTL;
        end
        W_CTL: if (wr_ack) begin
          wr_req <= 1'b0;
          st     <= W_IDLE;
        end
        default: st <= W_IDLE;
      endcase
    end
  end

  assign sts_ready = (st == W_IDLE) && !trk_empty;
  assign trk_pop   = (st == W_CTL) && wr_ack;

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (wr_req && !wr_ack) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));
endmodule

// File: rtl/sgd_walker.sv
module sgd_walker import sgd_pkg::*; #(
  parameter int MAX_OUT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              csr_we,
  input  logic [1:0]        csr_addr,
  input  logic [WORD_W-1:0] csr_wdata,
  output logic [WORD_W-1:0] csr_rdata,
  output logic              irq,
  output logic              rd_req,
  output logic [WORD_W-1:0] rd_addr,
  input  logic              rd_valid,
  input  logic [WORD_W-1:0] rd_data,
  output logic              wr_req,
  output logic [WORD_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  input  logic              wr_ack,
  output logic              rcmd_valid,
  input  logic              rcmd_ready,
  output logic [WORD_W-1:0] rcmd_src,
  output logic [LEN_W-1:0]  rcmd_len,
  output logic              rcmd_incr,
  output logic              wcmd_valid,
  input  logic              wcmd_ready,
  output logic [WORD_W-1:0] wcmd_dst,
  output logic [LEN_W-1:0]  wcmd_len,
  output logic              wcmd_incr,
  output logic              wcmd_pkt,
  input  logic              sts_valid,
  output logic              sts_ready,
  input  logic [WORD_W-1:0] sts_bytes
);
  localparam int CW = $clog2(MAX_OUT + 1);
  localparam int RW = $bits(rd_cmd_t);
  localparam int WW = $bits(wr_cmd_t);
  localparam int TW = $bits(trk_t);

  logic [WORD_W-1:0] head_q;
  logic              busy_q, done_q, start, finish, issue;
  rd_cmd_t           rcmd_in, rcmd_out;
  wr_cmd_t           wcmd_in, wcmd_out;
  trk_t              trk_in, trk_out;
  logic [RW-1:0]     rq_dout;
  logic [WW-1:0]     wq_dout;
  logic [TW-1:0]     tq_dout;
  logic              rq_full, rq_empty, wq_full, wq_empty, tq_full, tq_empty, tq_pop;
  logic [CW-1:0]     rq_cnt, wq_cnt, tq_cnt;

  assign start = csr_we && (csr_addr == 2'd1) && csr_wdata[0] && !busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q    <= '0;
      busy_q    <= 1'b0;
      done_q    <= 1'b0;
      csr_rdata <= '0;
    end else begin
      if (csr_we && (csr_addr == 2'd0)) head_q <= csr_wdata;
      if (start) begin
        busy_q <= 1'b1;
        done_q <= 1'b0;
      end else if (finish) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
      end else if (csr_we && (csr_addr == 2'd1) && csr_wdata[1]) begin
        done_q <= 1'b0;
      end
      case (csr_addr)
        2'd0:    csr_rdata <= head_q;
        2'd1:    csr_rdata <= {{(WORD_W-2){1'b0}}, done_q, busy_q};
        default: csr_rdata <= '0;
      endcase
    end
  end

  assign irq = done_q;

  sgd_fetch #(.MAX_OUT(MAX_OUT)) u_fetch (
    .clk, .rst, .start, .head(head_q), .trk_count(tq_cnt), .trk_empty(tq_empty),
    .rd_req, .rd_addr, .rd_valid, .rd_data, .issue,
    .rcmd(rcmd_in), .wcmd(wcmd_in), .trk_ent(trk_in), .finish
  );

  sgd_fifo #(.W(RW), .DEPTH(MAX_OUT)) u_rq (
    .clk, .rst, .push(issue), .din(rcmd_in), .pop(rcmd_valid && rcmd_ready),
    .dout(rq_dout), .full(rq_full), .empty(rq_empty), .count(rq_cnt)
  );

  sgd_fifo #(.W(WW), .DEPTH(MAX_OUT)) u_wq (
    .clk, .rst, .push(issue), .din(wcmd_in), .pop(wcmd_valid && wcmd_ready),
    .dout(wq_dout), .full(wq_full), .empty(wq_empty), .count(wq_cnt)
  );

  sgd_fifo #(.W(TW), .DEPTH(MAX_OUT)) u_tq (
    .clk, .rst, .push(issue), .din(trk_in), .pop(tq_pop),
    .dout(tq_dout), .full(tq_full), .empty(tq_empty), .count(tq_cnt)
  );

  assign rcmd_out   = rq_dout;
  assign wcmd_out   = wq_dout;
  assign trk_out    = tq_dout;
  assign rcmd_valid = !rq_empty;
  assign wcmd_valid = !wq_empty;
  assign rcmd_src   = rcmd_out.addr;
  assign rcmd_len   = rcmd_out.len;
  assign rcmd_incr  = rcmd_out.incr;
  assign wcmd_dst   = wcmd_out.addr;
  assign wcmd_len   = wcmd_out.len;
  assign wcmd_incr  = wcmd_out.incr;
  assign wcmd_pkt   = wcmd_out.pkt;

  sgd_writeback u_wb (
    .clk, .rst, .trk_empty(tq_empty), .trk_head(trk_out), .trk_pop(tq_pop),
    .sts_valid, .sts_ready, .sts_bytes, .wr_req, .wr_addr, .wr_data, .wr_ack
  );

  assert_ready_busy_R10: assert property (@(posedge clk) disable iff (rst)
    sts_ready |-> busy_q);
  assert_irq_idle_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(irq) |-> !busy_q);
  assert_cmd_bound_R6: assert property (@(posedge clk) disable iff (rst)
    (rq_cnt <= tq_cnt) && (wq_cnt <= tq_cnt));
  assert_issue_room_R6: assert property (@(posedge clk) disable iff (rst)
    issue |-> (!rq_full && !wq_full && !tq_full));
  assert_start_ignored_R9: assert property (@(posedge clk) disable iff (rst)
    (busy_q && !finish) |=> busy_q);
endmodule

// File: tb/sgd_walker_test.sv
module sgd_walker_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        csr_we = 1'b0;
  logic [1:0]  csr_addr = 2'd0;
  logic [31:0] csr_wdata = '0;
  logic [31:0] csr_rdata;
  logic        irq, rd_req, rd_valid, wr_req, wr_ack;
  logic [31:0] rd_addr, rd_data, wr_addr, wr_data;
  logic        rcmd_valid, rcmd_ready, rcmd_incr;
  logic        wcmd_valid, wcmd_ready, wcmd_incr, wcmd_pkt;
  logic [31:0] rcmd_src, wcmd_dst, sts_bytes;
  logic [15:0] rcmd_len, wcmd_len;
  logic        sts_valid, sts_ready;

  always #4 clk = ~clk;

  sgd_walker uut (
    .clk, .rst, .csr_we, .csr_addr, .csr_wdata, .csr_rdata, .irq,
    .rd_req, .rd_addr, .rd_valid, .rd_data, .wr_req, .wr_addr, .wr_data, .wr_ack,
    .rcmd_valid, .rcmd_ready, .rcmd_src, .rcmd_len, .rcmd_incr,
    .wcmd_valid, .wcmd_ready, .wcmd_dst, .wcmd_len, .wcmd_incr, .wcmd_pkt,
    .sts_valid, .sts_ready, .sts_bytes
  );

  int tests = 0, fails = 0, cyc = 0, mode = 0;
  logic [31:0] mem [0:255];
  logic [31:0] rlog [0:31];
  logic [31:0] rsrc [0:7], wdst [0:7], tok [0:7];
  logic [16:0] rcm [0:7];
  logic [17:0] wcm [0:7];
  int rlog_n, rc, wc, tr, dly, outst, outst_max;

  // behavioural memory, engines and token source
  always @(posedge clk) begin : models
    int d;
    if (rst) begin
      rd_valid <= 1'b0; wr_ack <= 1'b0; rd_data <= '0; rlog_n <= 0;
      rcmd_ready <= 1'b0; wcmd_ready <= 1'b0; rc <= 0; wc <= 0; tr <= 0;
      sts_valid <= 1'b0; sts_bytes <= '0; dly <= 0; outst <= 0; outst_max <= 0;
    end else begin
      rd_valid <= rd_req && !rd_valid;
      if (rd_req && !rd_valid) begin
        rd_data <= mem[rd_addr[9:2]];
        if (rlog_n < 32) rlog[rlog_n] <= rd_addr;
        rlog_n <= rlog_n + 1;
      end
      wr_ack <= wr_req && !wr_ack;
      if (wr_req && !wr_ack) mem[wr_addr[9:2]] <= wr_data;
      d = 0;
      if (rd_valid && rd_addr[4:0] == 5'd12 && rd_data[31]) d = d + 1;
      if (wr_req && !wr_ack && wr_addr[4:0] == 5'd12) d = d - 1;
      outst <= outst + d;
      if (outst + d > outst_max) outst_max <= outst + d;
      rcmd_ready <= (mode == 1) ? ~rcmd_ready : 1'b1;
      wcmd_ready <= (mode == 1) ? ~wcmd_ready : 1'b1;
      if (rcmd_valid && rcmd_ready && rc < 8) begin
        rsrc[rc] <= rcmd_src; rcm[rc] <= {rcmd_incr, rcmd_len}; rc <= rc + 1;
      end
      if (wcmd_valid && wcmd_ready && wc < 8) begin
        wdst[wc] <= wcmd_dst; wcm[wc] <= {wcmd_pkt, wcmd_incr, wcmd_len};
        tok[wc] <= 32'(wcmd_len) - 32'(wc % 3); wc <= wc + 1;
      end
      if (sts_valid && sts_ready) begin
        sts_valid <= 1'b0; tr <= tr + 1; dly <= 0;
      end else if (!sts_valid && tr < wc) begin
        if (dly >= ((mode == 0) ? 0 : (mode == 1) ? 3 : 20)) begin
          sts_valid <= 1'b1; sts_bytes <= tok[tr];
        end else dly <= dly + 1;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic csr_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); csr_we = 1'b1; csr_addr = a; csr_wdata = d;
    @(negedge clk); csr_we = 1'b0;
  endtask

  task automatic csr_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); csr_addr = a;
    @(negedge clk); d = csr_rdata;
  endtask

  function automatic logic [31:0] base_of(input int i, input int md);
    return 32'(64 + ((i * 5 + md) % 8) * 32);
  endfunction

  function automatic logic [31:0] ctl_of(input int i, input int n, input int md);
    logic [31:0] c;
    c = 32'h8000_0000 | (32'(i) << 20) | (32'((i + n) & 1) << 18)
      | (32'((i & 1) ^ (md == 2 ? 1 : 0)) << 17) | (32'((i + md) & 1) << 16)
      | 32'(16 + i * 8 + n);
    return c;
  endfunction

  task automatic run(input int n, input int md);
    logic [31:0] v, b, c, e;
    mode = md;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    chk("R1 irq after reset", {31'b0, irq}, 0);
    chk("R1 masters idle after reset", {30'b0, rd_req, wr_req}, 0);
    chk("R1 commands empty after reset", {30'b0, rcmd_valid, wcmd_valid}, 0);
    chk("R1 R10 sts_ready after reset", {31'b0, sts_ready}, 0);
    for (int w = 0; w < 256; w++) mem[w] = 32'h0;
    for (int i = 0; i < n; i++) begin
      b = base_of(i, md);
      mem[b[9:2]]     = 32'h1000_0000 + 32'(i * 256 + n);
      mem[b[9:2] + 1] = 32'h2000_0000 + 32'(i * 16 + md);
      mem[b[9:2] + 2] = base_of(i + 1, md);
      mem[b[9:2] + 3] = ctl_of(i, n, md);
    end
    b = base_of(n, md);
    mem[b[9:2] + 3] = 32'h0000_0055;
    csr_read(2'd0, v);  chk("R1 head reg after reset", v, 0);
    csr_read(2'd1, v);  chk("R1 status reg after reset", v, 0);
    csr_write(2'd0, base_of(0, md));
    csr_read(2'd0, v);  chk("R2 head readback", v, base_of(0, md));
    csr_write(2'd1, 32'h1);
    if (n >= 1) begin
      repeat (3) @(negedge clk);
      csr_write(2'd0, 32'h0000_03E0);   // R2: head change after start
      csr_write(2'd1, 32'h1);           // R9: start while busy
    end
    for (int k = 0; k < 3000 && !irq; k++) @(negedge clk);
    chk("R8 irq raised at end of walk", {31'b0, irq}, 1);
    repeat (5) @(negedge clk);
    chk("R8 irq held", {31'b0, irq}, 1);
    csr_read(2'd1, v);  chk("R8 status done=1 busy=0", v, 32'h2);
    chk("R10 sts_ready low when idle", {31'b0, sts_ready}, 0);
    chk("R4 R5 read commands issued", 32'(rc), 32'(n));
    chk("R4 R5 write commands issued", 32'(wc), 32'(n));
    chk("R3 R5 R9 read count", 32'(rlog_n), 32'(4 * n + 1));
    for (int i = 0; i < n && i < 8; i++) begin
      b = base_of(i, md);
      c = ctl_of(i, n, md);
      chk("R3 R9 read order ctl", rlog[4 * i],     b + 12);
      chk("R3 read order src",    rlog[4 * i + 1], b);
      chk("R3 read order dst",    rlog[4 * i + 2], b + 4);
      chk("R3 read order next",   rlog[4 * i + 3], b + 8);
      chk("R4 read cmd src", rsrc[i], 32'h1000_0000 + 32'(i * 256 + n));
      chk("R4 read cmd len/incr", {15'b0, rcm[i]}, {15'b0, c[16], c[15:0]});
      chk("R4 write cmd dst", wdst[i], 32'h2000_0000 + 32'(i * 16 + md));
      chk("R4 write cmd len/incr/pkt", {14'b0, wcm[i]}, {14'b0, c[18], c[17], c[15:0]});
      e = 32'(16 + i * 8 + n) - 32'(i % 3);
      chk("R7 status word bytes", mem[b[9:2] + 4], e);
      chk("R7 ctl word owner cleared", mem[b[9:2] + 3], c & 32'h7FFF_FFFF);
    end
    b = base_of(n, md);
    chk("R5 terminal ctl read", rlog[4 * n], b + 12);
    chk("R5 terminal ctl untouched", mem[b[9:2] + 3], 32'h0000_0055);
    chk("R5 terminal status untouched", mem[b[9:2] + 4], 32'h0);
    chk("R6 outstanding bound", {31'b0, outst_max <= 2}, 1);
    if (md == 2 && n >= 2) chk("R6 window filled", 32'(outst_max), 2);
    csr_write(2'd1, 32'h2);
    chk("R8 irq cleared by write", {31'b0, irq}, 0);
    csr_read(2'd1, v);  chk("R8 status after clear", v, 0);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      tests++; fails++;
      $display("FAIL watchdog R8 actual=%0d expected<150000 cycles", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    for (int md = 0; md < 3; md++)
      for (int n = 0; n < 5; n++)
        run(n, md);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule